// File: doc/BRIEF.md
# Eight-bit Timer with Clear-on-Compare

This block is an up-counting timer whose count advances once for every cycle on which an external prescaler raises a count-enable tick. A three-bit mode field picks one of two counting sequences. In free-running mode the count climbs to its maximum, rolls over to zero and keeps going. In clear-on-compare mode the count returns to zero on the tick where it equals a compare register, so the compare value sets the period.

Software reaches the count, the compare value, the mode and a two-bit output action through one write port, one register per cycle. The block reports two sticky flags: an overflow flag and a compare-match flag. An acknowledge pulse for each flag clears it, and so does a write of one to the flag register. A compare output pin responds to every match according to the action field: it is held low, toggled, cleared or set.

The compare register is unbuffered. Software that lowers it below the present count makes the counter miss the match. The counter then runs up to its maximum, wraps to zero and matches only on the following pass. Control and status pins are plain levels and carry no handshake.

Top module: `cmp_timer8`

## Requirements
- R1: After a synchronous reset the count, both flags and the output pin are 0. The compare register is 0, the mode is free-running and the action is 0.
- R2: The count changes only on a cycle where `tick_i` is 1 or the count register is written. With no tick and no count write, the count holds.
- R3: With mode code 0, the count increments by one on each tick and rolls over from 0xFF to 0x00. A compare match never clears it.
- R4: The overflow flag becomes 1 at the same clock edge at which a tick takes the count from 0xFF to 0x00. The rollover may come from an increment or from a compare clear. Hardware never clears this flag.
- R5: With mode code 2, a tick on which the count equals the compare register loads the count with 0 instead of incrementing it.
- R6: The compare flag becomes 1 after every tick on which the count equals the compare register, in any mode. Hardware never clears this flag.
- R7: A compare write is used from the next cycle onwards. If the new value is below the present count, no match happens until the counter passes 0xFF, wraps to 0 and climbs to the new value.
- R8: A count write (address 0) loads `wr_data_i` and overrides increment and clear in that cycle. It also suppresses that cycle's compare match and rollover, so neither flag is set and the pin does not change.
- R9: On a match the pin follows the action field (address 3, bits 1:0): 1 toggles it, 2 drives it to 0, 3 drives it to 1. While the action is 0 the pin is driven to 0 on every cycle. The pin changes at the same edge that sets the compare flag.
- R10: `ovf_ack_i` clears the overflow flag and `cmp_ack_i` clears the compare flag. A write to address 4 clears the overflow flag when bit 0 is 1 and the compare flag when bit 1 is 1. A hardware set in the same cycle wins over any clear.
- R11: The mode is written at address 2, bits 2:0. Every code other than 2 behaves exactly as code 0. The compare register is written at address 1. Addresses 5 to 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Count enable from the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select: 0 count, 1 compare, 2 mode, 3 action, 4 flag clear |
| wr_data_i | input | CNT_W | Write data |
| ovf_ack_i | input | 1 | Overflow interrupt acknowledge |
| cmp_ack_i | input | 1 | Compare interrupt acknowledge |
| count_o | output | CNT_W | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| cmp_flag_o | output | 1 | Sticky compare-match flag |
| oc_pin_o | output | 1 | Compare output pin |

## Verification
The bench lowers the compare value below a running count. A design with a buffered or magnitude-based compare would clear early, where the correct one must run on through 0xFF before it matches. It writes the count on the very tick that would have matched. A design that lets the match through would clear the count, set the flag or move the pin. It acknowledges the overflow flag on the same cycle as a rollover, where a clear-priority flag would come out 0. It also drives non-zero mode codes other than 2, which a design that decodes only bit 1 would treat as clear-on-compare. A behavioural model compared every cycle under random ticks, writes and acknowledges catches sequencing slips, such as a pin or flag that moves one tick late.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam int MODE_W = 3;
  localparam int ACT_W  = 2;

  localparam logic [MODE_W-1:0] MODE_CTC = 3'd2;

  typedef enum logic [ADDR_W-1:0] {
    REG_COUNT = 3'd0,
    REG_CMP   = 3'd1,
    REG_MODE  = 3'd2,
    REG_ACT   = 3'd3,
    REG_FLAGS = 3'd4
  } reg_addr_e;

  typedef enum logic [ACT_W-1:0] {
    ACT_OFF = 2'd0,
    ACT_TGL = 2'd1,
    ACT_CLR = 2'd2,
    ACT_SET = 2'd3
  } pin_act_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cmp_o,
  output logic             ctc_o,
  output pin_act_e         act_o,
  output logic             cnt_wr_o,
  output logic [1:0]       flag_w1c_o
);
  logic [MODE_W-1:0] mode_q;
  logic              sel_cnt, sel_cmp, sel_mode, sel_act, sel_flg;

  // address decode
  assign sel_cnt  = wr_en_i && (wr_addr_i == REG_COUNT);
  assign sel_cmp  = wr_en_i && (wr_addr_i == REG_CMP);
  assign sel_mode = wr_en_i && (wr_addr_i == REG_MODE);
  assign sel_act  = wr_en_i && (wr_addr_i == REG_ACT);
  assign sel_flg  = wr_en_i && (wr_addr_i == REG_FLAGS);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmp_o  <= '0;
      mode_q <= '0;
      act_o  <= ACT_OFF;
    end else begin
      if (sel_cmp)  cmp_o  <= wr_data_i;
      if (sel_mode) mode_q <= wr_data_i[MODE_W-1:0];
      if (sel_act)  act_o  <= pin_act_e'(wr_data_i[ACT_W-1:0]);
    end
  end

  assign ctc_o      = (mode_q == MODE_CTC);
  assign cnt_wr_o   = sel_cnt;
  assign flag_w1c_o = sel_flg ? wr_data_i[1:0] : 2'b00;

  AST_CMP_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    sel_cmp |=> cmp_o == $past(wr_data_i)); // R7
  AST_ODD_ADDR_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && wr_addr_i > REG_FLAGS) |=> ($stable(cmp_o) && $stable(act_o) && $stable(ctc_o))); // R11
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             ctc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o,
  output logic             wrap_o
);
  logic adv;
  logic eq;

  assign adv     = tick_i && !cnt_wr_i;
  assign eq      = (cnt_o == cmp_i);
  assign match_o = adv && eq;
  assign wrap_o  = adv && (&cnt_o);

  always_ff @(posedge clk_i) begin
    if (rst_i)              cnt_o <= '0;
    else if (cnt_wr_i)      cnt_o <= wr_data_i;
    else if (tick_i) begin
      if (ctc_i && eq)      cnt_o <= '0;
      else                  cnt_o <= cnt_o + 1'b1;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
    (!tick_i && !cnt_wr_i) |=> $stable(cnt_o)); // R2
  AST_ROLLOVER: assert property (@(posedge clk_i) disable iff (rst_i)
    wrap_o |=> (cnt_o == '0)); // R3
  AST_FREE_NO_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv && !ctc_i && !(&cnt_o)) |=> (cnt_o == $past(cnt_o) + 1'b1)); // R3
  AST_CTC_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv && ctc_i && eq) |=> (cnt_o == '0)); // R5
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_wr_i |=> (cnt_o == $past(wr_data_i))); // R8
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)      flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    set_i |=> flag_o); // R10
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (rst_i)
    (clr_i && !set_i) |=> !flag_o); // R10
  AST_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_o && !clr_i) |=> flag_o); // R6
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import tmr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  pin_act_e act_i,
  input  logic     match_i,
  output logic     pin_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) pin_o <= 1'b0;
    else begin
      unique case (act_i)
        ACT_OFF: pin_o <= 1'b0;
        ACT_TGL: if (match_i) pin_o <= ~pin_o;
        ACT_CLR: if (match_i) pin_o <= 1'b0;
        ACT_SET: if (match_i) pin_o <= 1'b1;
        default: pin_o <= 1'b0;
      endcase
    end
  end

  AST_PIN_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_i == ACT_OFF) |=> !pin_o); // R9
  AST_PIN_TOGGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    (match_i && act_i == ACT_TGL) |=> (pin_o != $past(pin_o))); // R9
  AST_PIN_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (!match_i && act_i != ACT_OFF) |=> $stable(pin_o)); // R8
endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     tick_i,
  input  logic                     wr_en_i,
  input  logic [tmr_pkg::ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]         wr_data_i,
  input  logic                     ovf_ack_i,
  input  logic                     cmp_ack_i,
  output logic [CNT_W-1:0]         count_o,
  output logic                     ovf_flag_o,
  output logic                     cmp_flag_o,
  output logic                     oc_pin_o
);
  localparam int N_FLAGS = 2;

  logic [CNT_W-1:0]   cmp_val;
  logic               ctc;
  pin_act_e           act;
  logic               cnt_wr;
  logic [N_FLAGS-1:0] w1c;
  logic               match, wrap;
  logic [N_FLAGS-1:0] f_set, f_clr, f_q;

  tmr_regs #(.CNT_W(CNT_W)) regs_i (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cmp_o(cmp_val), .ctc_o(ctc), .act_o(act),
    .cnt_wr_o(cnt_wr), .flag_w1c_o(w1c)
  );

  tmr_core #(.CNT_W(CNT_W)) core_i (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .cnt_wr_i(cnt_wr),
    .wr_data_i(wr_data_i), .cmp_i(cmp_val), .ctc_i(ctc),
    .cnt_o(count_o), .match_o(match), .wrap_o(wrap)
  );

  // flag 0 = overflow, flag 1 = compare
  assign f_set = {match, wrap};
  assign f_clr = {cmp_ack_i, ovf_ack_i} | w1c;

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    tmr_flag flag_i (
      .clk_i(clk_i), .rst_i(rst_i), .set_i(f_set[g]), .clr_i(f_clr[g]),
      .flag_o(f_q[g])
    );
  end

  assign ovf_flag_o = f_q[0];
  assign cmp_flag_o = f_q[1];

  tmr_pin pin_i (
    .clk_i(clk_i), .rst_i(rst_i), .act_i(act), .match_i(match), .pin_o(oc_pin_o)
  );

  AST_OVF_AT_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ovf_flag_o) |-> (count_o == '0)); // R4
  AST_CMP_FLAG_ON_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && !cnt_wr && count_o == cmp_val) |=> cmp_flag_o); // R6
endmodule

// File: tb/cmp_timer8_tb_top.sv
`timescale 1ns/1ps
module cmp_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic       ovf_ack = 1'b0;
  logic       cmp_ack = 1'b0;
  logic [7:0] count;
  logic       ovf_flag, cmp_flag, oc_pin;

  int n_tests = 0;
  int n_fail = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  // reference model state
  int m_cnt = 0, m_cmp = 0, m_mode = 0, m_act = 0;
  int m_ovf = 0, m_cf = 0, m_pin = 0;
  int cw, hit, rolled;

  always #10 clk = ~clk;

  cmp_timer8 #(.CNT_W(8)) dut_i (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ovf_ack_i(ovf_ack),
    .cmp_ack_i(cmp_ack), .count_o(count), .ovf_flag_o(ovf_flag),
    .cmp_flag_o(cmp_flag), .oc_pin_o(oc_pin)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // behavioural model
  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_mode = 0; m_act = 0;
      m_ovf = 0; m_cf = 0; m_pin = 0;
      chk_on = 1'b1;
    end else begin
      cw     = (wr_en && wr_addr == 3'd0) ? 1 : 0;
      hit    = (tick && !cw && m_cnt == m_cmp) ? 1 : 0;
      rolled = (tick && !cw && m_cnt == 255) ? 1 : 0;
      if (m_act == 0) m_pin = 0;
      else if (hit != 0) begin
        if (m_act == 1) m_pin = 1 - m_pin;
        else if (m_act == 2) m_pin = 0;
        else m_pin = 1;
      end
      if (rolled != 0) m_ovf = 1;
      else if (ovf_ack || (wr_en && wr_addr == 3'd4 && wr_data[0])) m_ovf = 0;
      if (hit != 0) m_cf = 1;
      else if (cmp_ack || (wr_en && wr_addr == 3'd4 && wr_data[1])) m_cf = 0;
      if (cw != 0) m_cnt = int'(wr_data);
      else if (tick) m_cnt = (m_mode == 2 && hit != 0) ? 0 : (m_cnt + 1) % 256;
      if (wr_en && wr_addr == 3'd1) m_cmp = int'(wr_data);
      if (wr_en && wr_addr == 3'd2) m_mode = int'(wr_data) % 8;
      if (wr_en && wr_addr == 3'd3) m_act = int'(wr_data) % 4;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (chk_on && !done) begin
      chk("R3/R5 count vs model", int'(count), m_cnt);
      chk("R4 overflow flag vs model", int'(ovf_flag), m_ovf);
      chk("R6 compare flag vs model", int'(cmp_flag), m_cf);
      chk("R9 pin vs model", int'(oc_pin), m_pin);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    // R1: reset state
    chk("R1 count", int'(count), 0);
    chk("R1 ovf", int'(ovf_flag), 0);
    chk("R1 cmp flag", int'(cmp_flag), 0);
    chk("R1 pin", int'(oc_pin), 0);

    // R2: no tick holds the count
    tick = 1'b0;
    cyc(5);
    chk("R2 hold", int'(count), 0);

    // R8 + R3 + R4: write FD with tick high, free-running rollover
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'hFD; tick = 1'b1;
    cyc(1);
    chk("R8 write over tick", int'(count), 253);
    wr_en = 1'b0;
    cyc(2);
    chk("R3 reaches FF", int'(count), 255);
    chk("R4 no ovf yet", int'(ovf_flag), 0);
    cyc(1);
    chk("R3 rollover", int'(count), 0);
    chk("R4 ovf set at zero", int'(ovf_flag), 1);
    cyc(1);
    chk("R3 no clear on match", int'(count), 1);
    chk("R6 match in free mode", int'(cmp_flag), 1);
    chk("R4 ovf sticky", int'(ovf_flag), 1);

    // R10: acknowledge and write-one-to-clear
    tick = 1'b0; cmp_ack = 1'b1;
    cyc(1);
    cmp_ack = 1'b0;
    chk("R10 cmp ack", int'(cmp_flag), 0);
    chk("R10 ovf untouched", int'(ovf_flag), 1);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h01;
    cyc(1);
    wr_en = 1'b0;
    chk("R10 w1c ovf", int'(ovf_flag), 0);

    // R5 + R9 toggle: compare 5, clear-on-compare
    wr(3'd1, 8'd5);
    wr(3'd3, 8'd1);
    wr(3'd2, 8'd2);
    wr(3'd0, 8'd0);
    tick = 1'b1;
    cyc(6);
    chk("R5 clear at compare", int'(count), 0);
    chk("R9 toggle high", int'(oc_pin), 1);
    cyc(6);
    chk("R9 toggle low", int'(oc_pin), 0);

    // R7: lower compare below count
    tick = 1'b0;
    wr(3'd0, 8'd150);
    wr(3'd1, 8'd100);
    wr(3'd4, 8'h03);
    tick = 1'b1;
    cyc(105);
    chk("R7 missed match runs on", int'(count), 255);
    chk("R7 no match flag", int'(cmp_flag), 0);
    cyc(1);
    chk("R7 wrap", int'(count), 0);
    chk("R4 ovf in ctc wrap", int'(ovf_flag), 1);
    cyc(100);
    chk("R7 climbs to new compare", int'(count), 100);
    cyc(1);
    chk("R7 match on next pass", int'(count), 0);
    chk("R7 flag on next pass", int'(cmp_flag), 1);

    // R8: count write suppresses a match
    cyc(100);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'd100; cmp_ack = 1'b1;
    cyc(1);
    wr_en = 1'b0; cmp_ack = 1'b0;
    chk("R8 no clear on write", int'(count), 100);
    chk("R8 no flag on write", int'(cmp_flag), 0);
    cyc(1);
    chk("R8 match next tick", int'(count), 0);

    // R11: other mode codes act as free-running
    tick = 1'b0;
    wr(3'd2, 8'd5);
    wr(3'd1, 8'd3);
    wr(3'd0, 8'd0);
    wr(3'd6, 8'd77);
    tick = 1'b1;
    cyc(5);
    chk("R11 mode 5 free-running", int'(count), 5);

    // R9 set / clear / off
    tick = 1'b0;
    wr(3'd2, 8'd2);
    wr(3'd0, 8'd0);
    wr(3'd3, 8'd3);
    tick = 1'b1;
    cyc(4);
    chk("R9 set action", int'(oc_pin), 1);
    tick = 1'b0;
    wr(3'd3, 8'd2);
    tick = 1'b1;
    cyc(4);
    chk("R9 clear action", int'(oc_pin), 0);
    tick = 1'b0;
    wr(3'd3, 8'd3);
    tick = 1'b1;
    cyc(4);
    chk("R9 set again", int'(oc_pin), 1);
    tick = 1'b0;
    wr(3'd3, 8'd0);
    cyc(1);
    chk("R9 off drives low", int'(oc_pin), 0);

    // R10: hardware set wins over acknowledge
    wr(3'd2, 8'd0);
    wr(3'd0, 8'hFF);
    wr(3'd4, 8'h03);
    tick = 1'b1; ovf_ack = 1'b1;
    cyc(1);
    tick = 1'b0; ovf_ack = 1'b0;
    chk("R10 set beats ack", int'(ovf_flag), 1);

    // random phase, model-checked every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick    = ($urandom % 3) != 0;
      ovf_ack = ($urandom % 16) == 0;
      cmp_ack = ($urandom % 16) == 0;
      wr_en   = ($urandom % 8) == 0;
      wr_addr = 3'($urandom % 6);
      wr_data = 8'($urandom);
      if (wr_addr == 3'd1) wr_data = 8'($urandom % 40);
      if (wr_addr == 3'd2 && ($urandom % 2) == 0) wr_data = 8'd2;
    end
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; ovf_ack = 1'b0; cmp_ack = 1'b0;
    cyc(2);
    finish_run();
  end
endmodule